// File: doc/BRIEF.md
# Banked RAM Self-Test Engine

This block is a built-in test sequencer for a buffer RAM that is seen through a bank-select window. The RAM is split into equal pages (banks). A small bank register picks which page the window shows, and the window itself is a 16-bit word port. On a single start pulse the engine runs four passes over the RAM, one after another. It fills every bank with a pattern tagged by the bank number and reads the pattern back. It then clears every bank to zero and checks that the clear took hold.

The pattern puts the bank index in the upper nibble of each word, so two banks that decode to the same physical storage read back wrong values. The first wrong word stops the test. The engine then reports the failing bank and word offset, and it reports pass or fail through status bits that stay set until the next run. A start request that arrives while a run is in progress is dropped.

Top module: `bank_ram_bist`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `passOk`, `failFlag`, `memEn` and `bankSelWr` are all low, and they stay low until a start is accepted.
- R2: Before it makes any access to a bank, the engine writes the bank register for one cycle. The written value is the bank index in the low bits with an enable bit set at the top bit `bankSelVal[BANK_W]`. Each pass visits banks 0 up to NUM_BANKS-1 and, inside each bank, words 0 up to WORDS_PER_BANK-1, with one access per cycle.
- R3: In the first pass every access is a write (`memWe` high). Its data is bank index × 0x1000 plus word index, taken modulo 2^16.
- R4: The second pass reads every word (`memWe` low). Read data is expected on `memRdata` in the cycle after the read, and the engine compares it with the same bank-tagged value.
- R5: The first read that does not match ends the run with `failFlag` set. `failBank` and `failWord` give the location of that read, and no further bank-register write or memory access follows until the next start.
- R6: If the second pass finds no mismatch, the third pass writes 0x0000 to every word of every bank in the same order.
- R7: The fourth pass reads every word again and expects 0x0000. A non-zero word fails with its location, as in R5. A run that finishes all four passes without a mismatch sets `passOk`.
- R8: The end of a run raises `done` for exactly one cycle. `passOk` and `failFlag` are never high together, and they hold their value until a start is accepted, which clears both.
- R9: `startReq` is acted on only while `busy` is low. A start request during a run changes neither the access sequence nor the run length.
- R10: If the memory ignores the bank register, so that all banks share one page, the run fails at bank 0 word 0 in the second pass whenever NUM_BANKS is above 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start request, sampled when idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| passOk | output | 1 | Sticky pass status |
| failFlag | output | 1 | Sticky fail status |
| failBank | output | BANK_W | Bank of the first mismatch |
| failWord | output | WORD_W | Word offset of the first mismatch |
| bankSelWr | output | 1 | Bank register write strobe |
| bankSelVal | output | BANK_W+1 | Enable bit (MSB) and bank index |
| memEn | output | 1 | Window access strobe |
| memWe | output | 1 | Access is a write |
| memAddr | output | WORD_W | Word offset inside the window |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, one cycle after a read |

## Verification
Any slip in the bank or word counters shows up at once on the access port. Such a slip produces a wrong address, a missing bank-register write ahead of word 0, or write data whose upper nibble does not match the selected bank, and the bench's port monitor catches each of these in the same cycle. A fault in the compare pipeline or the pass sequencing shows up by the end of the run: the status bits, the reported location and the total access count all differ from the values the bench predicts from the injected fault. Stuck bits, dropped clears and bank aliasing are each placed so that they expose a different one of the two verify passes.

// File: rtl/bank_bist_pkg.sv
package bank_bist_pkg;

  typedef enum logic [1:0] {
    PH_FILL   = 2'd0,
    PH_VERIFY = 2'd1,
    PH_CLEAR  = 2'd2,
    PH_CHECK  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SELECT = 2'd1,
    ST_ACCESS = 2'd2,
    ST_DRAIN  = 2'd3
  } state_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic restart;     // clear counters and status, begin a run
    logic wordStep;    // advance word offset
    logic bankStep;    // move to word 0 of next bank (wraps)
    logic bankWr;      // drive bank register write
    logic memEn;       // access the window this cycle
    logic memWe;       // access is a write
    logic zeroData;    // data / expectation is all zeros
    logic finishPass;  // end run with pass
    logic finishFail;  // end run with fail
  } strobe_t;

  localparam int unsigned BANK_TAG_SHIFT = 12;

  function automatic logic [15:0] tagWord(input int unsigned bank, input int unsigned word);
    return 16'((bank << BANK_TAG_SHIFT) + word);
  endfunction

endpackage

// File: rtl/bank_bist_ctrl.sv
module bank_bist_ctrl
  import bank_bist_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    lastWord,
  input  logic    lastBank,
  input  logic    mismatch,
  output strobe_t strobe,
  output logic    busy
);

  state_e state, stateNext;
  phase_e phase, phaseNext;
  strobe_t s;

  always_comb begin
    s         = '0;
    stateNext = state;
    phaseNext = phase;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          s.restart = 1'b1;
          stateNext = ST_SELECT;
          phaseNext = PH_FILL;
        end
      end
      ST_SELECT: begin
        if (mismatch) begin
          s.finishFail = 1'b1;
          stateNext    = ST_IDLE;
        end else begin
          s.bankWr  = 1'b1;
          stateNext = ST_ACCESS;
        end
      end
      ST_ACCESS: begin
        if (mismatch) begin
          s.finishFail = 1'b1;
          stateNext    = ST_IDLE;
        end else begin
          s.memEn    = 1'b1;
          s.memWe    = (phase == PH_FILL) || (phase == PH_CLEAR);
          s.zeroData = (phase == PH_CLEAR) || (phase == PH_CHECK);
          if (lastWord) begin
            s.bankStep = 1'b1;
            if (lastBank) begin
              case (phase)
                PH_FILL:   begin phaseNext = PH_VERIFY; stateNext = ST_SELECT; end
                PH_CLEAR:  begin phaseNext = PH_CHECK;  stateNext = ST_SELECT; end
                default:   stateNext = ST_DRAIN;
              endcase
            end else begin
              stateNext = ST_SELECT;
            end
          end else begin
            s.wordStep = 1'b1;
          end
        end
      end
      ST_DRAIN: begin
        stateNext = ST_IDLE;
        if (mismatch) begin
          s.finishFail = 1'b1;
        end else if (phase == PH_VERIFY) begin
          phaseNext = PH_CLEAR;
          stateNext = ST_SELECT;
        end else begin
          s.finishPass = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= PH_FILL;
    end else begin
      state <= stateNext;
      phase <= phaseNext;
    end
  end

  assign strobe = s;
  assign busy   = (state != ST_IDLE);

  // R5: a reported mismatch blocks any further access in that cycle
  a_r5_halt_on_mismatch: assert property (@(posedge clk) disable iff (!rstN)
    mismatch |-> (!strobe.memEn && !strobe.bankWr));

  // R9: a start seen while busy never restarts the run
  a_r9_no_restart_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |-> !strobe.restart);

endmodule

// File: rtl/bank_bist_dpath.sv
module bank_bist_dpath
  import bank_bist_pkg::*;
#(
  parameter int NUM_BANKS      = 8,
  parameter int WORDS_PER_BANK = 4096,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int WORD_W = (WORDS_PER_BANK > 1) ? $clog2(WORDS_PER_BANK) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  output logic              lastWord,
  output logic              lastBank,
  output logic              mismatch,
  output logic              done,
  output logic              passOk,
  output logic              failFlag,
  output logic [BANK_W-1:0] failBank,
  output logic [WORD_W-1:0] failWord,
  output logic              bankSelWr,
  output logic [BANK_W:0]   bankSelVal,
  output logic              memEn,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [15:0]       memWdata,
  input  logic [15:0]       memRdata
);

  localparam logic [BANK_W-1:0] BANK_MAX = BANK_W'(NUM_BANKS - 1);
  localparam logic [WORD_W-1:0] WORD_MAX = WORD_W'(WORDS_PER_BANK - 1);

  logic [BANK_W-1:0] bankCnt;
  logic [WORD_W-1:0] wordCnt;
  logic [15:0]       expVal;

  // read-compare pipeline: one stage matching the RAM read latency
  logic              cmpValid;
  logic [15:0]       cmpExp;
  logic [BANK_W-1:0] cmpBank;
  logic [WORD_W-1:0] cmpWord;

  logic              doneQ, passQ, failQ;
  logic [BANK_W-1:0] failBankQ;
  logic [WORD_W-1:0] failWordQ;

  assign lastWord = (wordCnt == WORD_MAX);
  assign lastBank = (bankCnt == BANK_MAX);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart) begin
      bankCnt <= '0;
      wordCnt <= '0;
    end else if (strobe.bankStep) begin
      wordCnt <= '0;
      bankCnt <= lastBank ? '0 : bankCnt + 1'b1;
    end else if (strobe.wordStep) begin
      wordCnt <= wordCnt + 1'b1;
    end
  end

  assign expVal = strobe.zeroData ? 16'h0000
                                  : tagWord(32'(bankCnt), 32'(wordCnt));

  assign bankSelWr  = strobe.bankWr;
  assign bankSelVal = {1'b1, bankCnt};
  assign memEn      = strobe.memEn;
  assign memWe      = strobe.memWe;
  assign memAddr    = wordCnt;
  assign memWdata   = expVal;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart) begin
      cmpValid <= 1'b0;
      cmpExp   <= '0;
      cmpBank  <= '0;
      cmpWord  <= '0;
    end else begin
      cmpValid <= strobe.memEn && !strobe.memWe;
      cmpExp   <= expVal;
      cmpBank  <= bankCnt;
      cmpWord  <= wordCnt;
    end
  end

  assign mismatch = cmpValid && (memRdata != cmpExp);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart) begin
      doneQ     <= 1'b0;
      passQ     <= 1'b0;
      failQ     <= 1'b0;
      failBankQ <= '0;
      failWordQ <= '0;
    end else begin
      doneQ <= strobe.finishPass || strobe.finishFail;
      if (strobe.finishPass) begin
        passQ <= 1'b1;
      end
      if (strobe.finishFail) begin
        failQ     <= 1'b1;
        failBankQ <= cmpBank;
        failWordQ <= cmpWord;
      end
    end
  end

  assign done     = doneQ;
  assign passOk   = passQ;
  assign failFlag = failQ;
  assign failBank = failBankQ;
  assign failWord = failWordQ;

  // R8: done lasts a single cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: pass and fail status are exclusive
  a_r8_status_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(passOk && failFlag));

  // R8: status holds while no run is started or finished
  a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.restart && !strobe.finishPass && !strobe.finishFail)
      |=> ($stable(passOk) && $stable(failFlag)));

endmodule

// File: rtl/bank_ram_bist.sv
module bank_ram_bist
  import bank_bist_pkg::*;
#(
  parameter int NUM_BANKS      = 8,
  parameter int WORDS_PER_BANK = 4096,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int WORD_W = (WORDS_PER_BANK > 1) ? $clog2(WORDS_PER_BANK) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  output logic              busy,
  output logic              done,
  output logic              passOk,
  output logic              failFlag,
  output logic [BANK_W-1:0] failBank,
  output logic [WORD_W-1:0] failWord,
  output logic              bankSelWr,
  output logic [BANK_W:0]   bankSelVal,
  output logic              memEn,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [15:0]       memWdata,
  input  logic [15:0]       memRdata
);

  strobe_t strobe;
  logic    lastWord, lastBank, mismatch;

  bank_bist_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .lastWord (lastWord),
    .lastBank (lastBank),
    .mismatch (mismatch),
    .strobe   (strobe),
    .busy     (busy)
  );

  bank_bist_dpath #(
    .NUM_BANKS      (NUM_BANKS),
    .WORDS_PER_BANK (WORDS_PER_BANK)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .lastWord   (lastWord),
    .lastBank   (lastBank),
    .mismatch   (mismatch),
    .done       (done),
    .passOk     (passOk),
    .failFlag   (failFlag),
    .failBank   (failBank),
    .failWord   (failWord),
    .bankSelWr  (bankSelWr),
    .bankSelVal (bankSelVal),
    .memEn      (memEn),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memRdata   (memRdata)
  );

  // R2: word 0 of a bank is always preceded by a bank register write
  a_r2_select_before_word0: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memAddr == '0) |-> $past(bankSelWr));

  // R8/R9: the run ends only together with the done pulse
  a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && !busy) |-> done);

  // R8: done is never raised while a run is active
  a_r8_done_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: tb/bank_ram_bist_bench.sv
module bank_ram_bist_bench;

  localparam int NB = 4;
  localparam int NW = 16;
  localparam int BW = 2;
  localparam int WW = 4;
  localparam int TOTAL = NB * NW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic          busy, done, passOk, failFlag;
  logic [BW-1:0] failBank;
  logic [WW-1:0] failWord;
  logic          bankSelWr;
  logic [BW:0]   bankSelVal;
  logic          memEn, memWe;
  logic [WW-1:0] memAddr;
  logic [15:0]   memWdata;
  logic [15:0]   memRdata;

  always #5 clk = ~clk;

  bank_ram_bist #(.NUM_BANKS(NB), .WORDS_PER_BANK(NW)) u_bank_ram_bist (
    .clk(clk), .rstN(rstN), .startReq(startReq), .busy(busy), .done(done),
    .passOk(passOk), .failFlag(failFlag), .failBank(failBank), .failWord(failWord),
    .bankSelWr(bankSelWr), .bankSelVal(bankSelVal), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  int errors = 0;
  int checks = 0;

  // memory model and fault knobs
  logic [15:0]   ram [TOTAL];
  logic [15:0]   rdataQ = 16'h0;
  logic [BW-1:0] selBank = '0;
  bit            aliasMode = 0;
  bit            faultEn = 0;
  int            faultIdx = 0;
  logic [15:0]   faultMask = 16'h0;
  bit            dropZero = 0;
  int            dropIdx = 0;

  int accCount = 0;
  int monErr = 0;
  int strayAcc = 0;
  int ph, eb, ew, phys;

  assign memRdata = rdataQ;

  function automatic logic [15:0] pat(input int b, input int w);
    return 16'(b * 4096 + w);
  endfunction

  always @(posedge clk) begin
    if (rstN) begin
      if (startReq && !busy) accCount = 0;
      if (bankSelWr) begin
        if (!bankSelVal[BW]) monErr++;
        selBank <= bankSelVal[BW-1:0];
      end
      if (memEn) begin
        ph = accCount / TOTAL;
        eb = (accCount / NW) % NB;
        ew = accCount % NW;
        if (int'(selBank) != eb || int'(memAddr) != ew) monErr++;
        if (memWe != (ph == 0 || ph == 2)) monErr++;
        if (memWe && memWdata != ((ph == 0) ? pat(eb, ew) : 16'h0)) monErr++;
        phys = aliasMode ? int'(memAddr) : int'(selBank) * NW + int'(memAddr);
        if (memWe) begin
          if (!(dropZero && phys == dropIdx && memWdata == 16'h0)) ram[phys] <= memWdata;
        end else begin
          rdataQ <= ram[phys] | ((faultEn && phys == faultIdx) ? faultMask : 16'h0);
        end
        if (!busy) strayAcc++;
        accCount++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // expected outcome for a single stuck-at-one mask at (b,w)
  task automatic predictStuck(input int b, input int w, input logic [15:0] mask,
                              output bit expPass, output int expAcc);
    logic [15:0] p;
    p = pat(b, w);
    if (mask == 16'h0) begin
      expPass = 1; expAcc = 4 * TOTAL;
    end else if ((p | mask) != p) begin
      expPass = 0; expAcc = TOTAL + b * NW + w + 1;
    end else begin
      expPass = 0; expAcc = 3 * TOTAL + b * NW + w + 1;
    end
  endtask

  task automatic runTest(input bit expPass, input int expBank, input int expWord,
                         input int expAcc, input int disturbAt, output int cyc);
    int monBefore;
    monBefore = monErr;
    strayAcc = 0;
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    cyc = 1;
    chk(busy == 1'b1 && passOk == 1'b0 && failFlag == 1'b0, "R8 status cleared on start",
        {busy, passOk, failFlag}, 3'b100);
    while (!done && cyc < 5000) begin
      startReq = (cyc == disturbAt);
      @(negedge clk);
      cyc++;
    end
    startReq = 1'b0;
    chk(done == 1'b1, "R8 done raised (watchdog)", done, 1);
    chk(passOk == expPass && failFlag == !expPass, expPass ? "R7 pass status" : "R5 fail status",
        {passOk, failFlag}, {expPass, !expPass});
    if (!expPass) begin
      chk(int'(failBank) == expBank, "R5 fail bank", failBank, expBank);
      chk(int'(failWord) == expWord, "R5 fail word", failWord, expWord);
    end
    chk(accCount == expAcc, "R6 access count per pass order", accCount, expAcc);
    chk(monErr == monBefore, "R2 R3 R4 access order and data", monErr - monBefore, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", done, 0);
    repeat (5) @(negedge clk);
    chk(passOk == expPass && failFlag == !expPass, "R8 status sticky",
        {passOk, failFlag}, {expPass, !expPass});
    chk(strayAcc == 0 && busy == 1'b0, "R5 no access after end", strayAcc, 0);
  endtask

  initial begin
    #1_500_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cleanCyc, cyc, b, w;
    bit ep;
    int ea;
    logic [15:0] m;
    void'($urandom(32'd20240611));
    for (int i = 0; i < TOTAL; i++) ram[i] = 16'($urandom);

    repeat (3) @(negedge clk);
    chk({busy, done, passOk, failFlag, memEn, bankSelWr} == 6'b0, "R1 outputs in reset",
        {busy, done, passOk, failFlag, memEn, bankSelWr}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, done, passOk, failFlag, memEn, bankSelWr} == 6'b0, "R1 idle after reset",
        {busy, done, passOk, failFlag, memEn, bankSelWr}, 0);

    // clean run
    runTest(1, 0, 0, 4 * TOTAL, -1, cleanCyc);

    // R9: start pulse in the middle of a run
    runTest(1, 0, 0, 4 * TOTAL, 30, cyc);
    chk(cyc == cleanCyc, "R9 run length unchanged by busy start", cyc, cleanCyc);

    // R10: bank register ignored by the memory
    aliasMode = 1;
    runTest(0, 0, 0, TOTAL + 1, -1, cyc);
    aliasMode = 0;

    // R7: clear dropped at the last word of the last bank
    dropZero = 1; dropIdx = TOTAL - 1;
    runTest(0, NB - 1, NW - 1, 4 * TOTAL, -1, cyc);
    dropZero = 0;

    // R4: stuck bit at bank 0 word 0 (bit 15 zero in pattern)
    faultEn = 1; faultIdx = 0; faultMask = 16'h8000;
    runTest(0, 0, 0, TOTAL + 1, -1, cyc);

    // R7: stuck bit already set in the pattern -> only zero check fails
    faultIdx = 3 * NW + 5; faultMask = 16'h1000;
    predictStuck(3, 5, faultMask, ep, ea);
    runTest(ep, 3, 5, ea, -1, cyc);

    // random stuck-at faults
    for (int k = 0; k < 10; k++) begin
      b = $urandom_range(0, NB - 1);
      w = $urandom_range(0, NW - 1);
      m = ($urandom_range(0, 4) == 0) ? 16'h0 : 16'(1 << $urandom_range(0, 15));
      faultIdx = b * NW + w; faultMask = m;
      predictStuck(b, w, m, ep, ea);
      runTest(ep, b, w, ea, -1, cyc);
    end
    faultEn = 0;

    // R3: final clean run after faults
    runTest(1, 0, 0, 4 * TOTAL, -1, cyc);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule